// File: doc/BRIEF.md
# Two-Byte Loaded Double-Buffered Converter Front End

This block is the digital side of a 12-bit converter fed over an 8-bit bus. A word is put together in two input registers: an 8-bit upper register and a 4-bit lower register. The lower register always takes the top four bus lines. Active-low select and first-write strobes, qualified by a byte-select level, decide which of the input registers capture the bus. A separate pair of active-low strobes, transfer and second write, then copies the assembled word into a 12-bit code register. That register drives the converter.

Two bus cycles fill a complete word. In the first cycle byte-select is high, and the upper register and the lower register load together. In the second cycle byte-select is low, and only the lower register reloads. The input stage and the code register are separate, so the host can stage a new word while the converter keeps the old one. A transfer is allowed at any time and moves whatever the input registers hold at that moment. All strobes are synchronous to the system clock. While a strobe condition is true, the affected register updates on every clock edge.

Top module: `byte_dac_front`

## Requirements
- R1: A synchronous active-high reset clears the upper register, the lower register and the code output to zero.
- R2: When `sel_n`=0, `wr_a_n`=0 and `byte_hi`=1, the upper register takes `bus[7:0]` and the lower register takes `bus[7:4]` on the same clock edge.
- R3: When `sel_n`=0, `wr_a_n`=0 and `byte_hi`=0, only the lower register loads, from `bus[7:4]`. The upper register keeps its value.
- R4: When `sel_n`=1 or `wr_a_n`=1, neither input register changes, whatever the bus and `byte_hi` carry.
- R5: When `move_n`=0 and `wr_b_n`=0, `code` on the next edge equals {upper, lower}. The upper register is `code[11:4]` and the lower register is `code[3:0]`.
- R6: If `move_n` or `wr_b_n` is 1, `code` holds its value. Loads into the input registers do not change `code`.
- R7: When a load and a transfer fall in the same clock, `code` takes the input register contents from before that load.
- R8: While a load condition stays true over several clocks, the register follows the bus on every edge and keeps the last value captured.
- R9: The code is passed to the output bit for bit, including all ones (0xFFF) and all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Select, active low, qualifies the first write |
| wr_a_n | input | 1 | First write strobe, active low |
| byte_hi | input | 1 | 1: load upper and lower registers; 0: load lower only |
| move_n | input | 1 | Transfer strobe, active low |
| wr_b_n | input | 1 | Second write strobe, active low, qualifies transfer |
| bus | input | 8 | Data bus; lines 7..4 also feed the lower register |
| code | output | 12 | Code register driving the converter |

## Verification
The bench targets the corner cases where the two stages interact. It fires a load and a transfer in the same cycle: a design that forwarded the new bus data would show the fresh word one transfer too early. It half-asserts each strobe pair. A design that ignored the gating would corrupt the latches or the code, which a later clean transfer exposes. It also runs a low-only write, to catch a design that disturbs the upper byte or takes the nibble from the wrong bus lines. Finally it holds a write over several cycles, to catch a design that captures only on the first edge.

// File: rtl/byte_dac_front_pkg.sv
package byte_dac_front_pkg;

    localparam int UPPER_BITS = 8;
    localparam int LOWER_BITS = 4;
    localparam int WORD_BITS  = UPPER_BITS + LOWER_BITS;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_LOW  = 2'd1,
        LD_BOTH = 2'd2
    } load_e;

    typedef struct packed {
        load_e load;
        logic  xfer;
    } strobe_ctrl_s;

    function automatic load_e pick_load(input logic sel_n, input logic wr_n,
                                        input logic byte_hi);
        if (sel_n || wr_n)
            return LD_NONE;
        return byte_hi ? LD_BOTH : LD_LOW;
    endfunction

endpackage

// File: rtl/dac_strobe_decode.sv
module dac_strobe_decode
    import byte_dac_front_pkg::*;
(
    input  logic         sel_n,
    input  logic         wr_a_n,
    input  logic         byte_hi,
    input  logic         move_n,
    input  logic         wr_b_n,
    output strobe_ctrl_s ctrl
);
    always_comb begin
        ctrl.load = pick_load(sel_n, wr_a_n, byte_hi);
        ctrl.xfer = ~(move_n | wr_b_n);
    end
endmodule

// File: rtl/dac_input_stage.sv
module dac_input_stage
    import byte_dac_front_pkg::*;
#(
    parameter int UPPER_W = UPPER_BITS,
    parameter int LOWER_W = LOWER_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  load_e              load,
    input  logic [UPPER_W-1:0] bus,
    output logic [UPPER_W-1:0] up_q,
    output logic [LOWER_W-1:0] lo_q
);
    localparam int NIB_LSB = UPPER_W - LOWER_W;

    logic [LOWER_W-1:0] nib;
    assign nib = bus[UPPER_W-1:NIB_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= '0;
            lo_q <= '0;
        end else begin
            case (load)
                LD_BOTH: begin
                    up_q <= bus;
                    lo_q <= nib;
                end
                LD_LOW:  lo_q <= nib;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dac_output_stage.sv
module dac_output_stage #(
    parameter int UPPER_W = 8,
    parameter int LOWER_W = 4,
    localparam int WORD_W = UPPER_W + LOWER_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               xfer,
    input  logic [UPPER_W-1:0] up_q,
    input  logic [LOWER_W-1:0] lo_q,
    output logic [WORD_W-1:0]  code
);
    always_ff @(posedge clk) begin
        if (rst)
            code <= '0;
        else if (xfer)
            code <= {up_q, lo_q};
    end
endmodule

// File: rtl/byte_dac_front.sv
module byte_dac_front
    import byte_dac_front_pkg::*;
#(
    parameter int UPPER_W = UPPER_BITS,
    parameter int LOWER_W = LOWER_BITS,
    localparam int WORD_W = UPPER_W + LOWER_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_n,
    input  logic               wr_a_n,
    input  logic               byte_hi,
    input  logic               move_n,
    input  logic               wr_b_n,
    input  logic [UPPER_W-1:0] bus,
    output logic [WORD_W-1:0]  code
);
    strobe_ctrl_s       ctrl;
    logic [UPPER_W-1:0] up_q;
    logic [LOWER_W-1:0] lo_q;

    dac_strobe_decode u_decode (
        .sel_n   (sel_n),
        .wr_a_n  (wr_a_n),
        .byte_hi (byte_hi),
        .move_n  (move_n),
        .wr_b_n  (wr_b_n),
        .ctrl    (ctrl)
    );

    dac_input_stage #(.UPPER_W(UPPER_W), .LOWER_W(LOWER_W)) u_in (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl.load),
        .bus  (bus),
        .up_q (up_q),
        .lo_q (lo_q)
    );

    dac_output_stage #(.UPPER_W(UPPER_W), .LOWER_W(LOWER_W)) u_out (
        .clk  (clk),
        .rst  (rst),
        .xfer (ctrl.xfer),
        .up_q (up_q),
        .lo_q (lo_q),
        .code (code)
    );
endmodule

// File: rtl/byte_dac_front_checker.sv
module byte_dac_front_checker #(
    parameter int UPPER_W = 8,
    parameter int LOWER_W = 4,
    localparam int WORD_W = UPPER_W + LOWER_W
) (
    input logic               clk,
    input logic               rst,
    input logic               sel_n,
    input logic               wr_a_n,
    input logic               byte_hi,
    input logic               move_n,
    input logic               wr_b_n,
    input logic [UPPER_W-1:0] bus,
    input logic [UPPER_W-1:0] up_q,
    input logic [LOWER_W-1:0] lo_q,
    input logic [WORD_W-1:0]  code
);
    p_both_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_a_n && byte_hi) |=>
            (up_q == $past(bus)) && (lo_q == $past(bus[UPPER_W-1 -: LOWER_W])));

    p_low_only_r3: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_a_n && !byte_hi) |=>
            $stable(up_q) && (lo_q == $past(bus[UPPER_W-1 -: LOWER_W])));

    p_no_load_r4: assert property (@(posedge clk) disable iff (rst)
        (sel_n || wr_a_n) |=> $stable(up_q) && $stable(lo_q));

    // R5 and R7: the code takes the register contents seen before the edge
    p_xfer_word_r5: assert property (@(posedge clk) disable iff (rst)
        (!move_n && !wr_b_n) |=> code == $past({up_q, lo_q}));

    p_code_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (move_n || wr_b_n) |=> $stable(code));
endmodule

bind byte_dac_front byte_dac_front_checker #(
    .UPPER_W(UPPER_W),
    .LOWER_W(LOWER_W)
) u_checker (
    .clk     (clk),
    .rst     (rst),
    .sel_n   (sel_n),
    .wr_a_n  (wr_a_n),
    .byte_hi (byte_hi),
    .move_n  (move_n),
    .wr_b_n  (wr_b_n),
    .bus     (bus),
    .up_q    (up_q),
    .lo_q    (lo_q),
    .code    (code)
);

// File: tb/byte_dac_front_bench.sv
`timescale 1ns/1ps
module byte_dac_front_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        sel_n, wr_a_n, byte_hi, move_n, wr_b_n;
    logic [7:0]  bus;
    logic [11:0] code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    byte_dac_front u_byte_dac_front (
        .clk     (clk),
        .rst     (rst),
        .sel_n   (sel_n),
        .wr_a_n  (wr_a_n),
        .byte_hi (byte_hi),
        .move_n  (move_n),
        .wr_b_n  (wr_b_n),
        .bus     (bus),
        .code    (code)
    );

    // {sel_n, wr_a_n, byte_hi, move_n, wr_b_n, bus[7:0], expected code after the edge}
    localparam int N = 20;
    localparam logic [24:0] VEC [N] = '{
        {5'b00111, 8'hA5, 12'h000},  // R2 load both, code unchanged
        {5'b11100, 8'h00, 12'hA5A},  // R5 transfer
        {5'b00011, 8'h3C, 12'hA5A},  // R3 low-only load
        {5'b11100, 8'h00, 12'hA53},  // R3 upper kept, nibble from bus[7:4]
        {5'b10111, 8'hFF, 12'hA53},  // R4 select high
        {5'b01111, 8'hFF, 12'hA53},  // R4 write high
        {5'b11101, 8'h00, 12'hA53},  // R6 move only
        {5'b11110, 8'h00, 12'hA53},  // R6 second write only
        {5'b11100, 8'h00, 12'hA53},  // R4 registers untouched
        {5'b00100, 8'hFF, 12'hA53},  // R7 load and move together
        {5'b11100, 8'h00, 12'hFFF},  // R9 all ones
        {5'b00000, 8'h00, 12'hFFF},  // R7 low load and move together
        {5'b11100, 8'h00, 12'hFF0},  // R3 low-only result
        {5'b00111, 8'h00, 12'hFF0},  // R6 load does not reach code
        {5'b11100, 8'h00, 12'h000},  // R9 all zeros
        {5'b00111, 8'h12, 12'h000},  // R8 held write
        {5'b00111, 8'h34, 12'h000},  // R8 held write
        {5'b00111, 8'h56, 12'h000},  // R8 held write
        {5'b11111, 8'hAA, 12'h000},  // R8 idle
        {5'b11100, 8'h00, 12'h565}   // R8 last captured value
    };
    localparam logic [15:0] TAG [N] = '{
        "R2", "R5", "R3", "R3", "R4", "R4", "R6", "R6", "R4", "R7",
        "R9", "R7", "R3", "R6", "R9", "R8", "R8", "R8", "R8", "R8"
    };

    task automatic drive(input logic [4:0] ctl, input logic [7:0] b);
        {sel_n, wr_a_n, byte_hi, move_n, wr_b_n} = ctl;
        bus = b;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [15:0] tag, input logic [11:0] exp);
        checks++;
        if (code !== exp) begin
            errors++;
            $display("FAIL %s: code=%h expected=%h", tag, code, exp);
        end
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        {sel_n, wr_a_n, byte_hi, move_n, wr_b_n} = 5'b11111;
        bus = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1", 12'h000);
        drive(5'b11100, 8'h00);
        check("R1", 12'h000);  // R1 registers cleared: transfer gives zero

        for (int i = 0; i < N; i++) begin
            drive(VEC[i][24:20], VEC[i][19:12]);
            check(TAG[i], VEC[i][11:0]);
        end

        // R1 reset mid-run clears code and latches
        drive(5'b00111, 8'h9C);
        drive(5'b11100, 8'h00);
        check("R5", 12'h9C9);
        rst = 1'b1;
        drive(5'b11111, 8'h00);
        rst = 1'b0;
        check("R1", 12'h000);
        drive(5'b11100, 8'h00);
        check("R1", 12'h000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule